// File: doc/BRIEF.md
# Parallel-Comparator Gray-Level Histogram

This block counts how the pixels of an 8-bit grayscale image spread over eight equal-width intensity ranges. Pixels arrive as a stream, one per accepted transfer. Every range has its own pair of bound comparators and its own counter, so each pixel is sorted in a single cycle by parallel compares rather than by a read-modify-write on a RAM.

A frame begins with a one-cycle start strobe, which clears every counter. The frame's pixels are then streamed in, and the final pixel is tagged with a last flag. One cycle after that pixel is counted, a done pulse is raised. From then on, software-independent logic can read any bin's count by driving its index on a plain select input.

The pixel input uses a valid/ready handshake. A pixel is taken on a clock edge where both valid and ready are high. Ready is low only while start is high, so start has priority and a pixel offered at the same time is refused and must be held. Ready does not depend on valid, and outside that case the block never applies back-pressure.

Top module: `intensity_hist`

## Requirements
- R1: After reset every bin count reads 0, done is low and ready is high.
- R2: An accepted pixel of value v adds exactly one to bin floor(v/32), for v from 0 to 255, and leaves the other seven bins unchanged. Bins are indexed 0 to 7.
- R3: The bin ranges are half-open, [32k, 32k+32). Every value maps to exactly one bin: 0 and 31 go to bin 0, 32 goes to bin 1, and 255 goes to bin 7.
- R4: A cycle in which valid is low changes no count and raises no done, whatever the data and last inputs carry.
- R5: A start strobe clears all eight counts to 0 on the next edge. While start is high, ready is low and no pixel is accepted.
- R6: Done is high for exactly one cycle, the cycle after the edge that accepted a pixel tagged last. Done is low at all other times.
- R7: Counts accumulate over the whole stream, and their sum equals the number of accepted pixels. A frame of MAX_PIXELS pixels in a single bin reads back MAX_PIXELS without wrapping.
- R8: The read output shows, in the same cycle, the count of the bin whose index is on the read select input.
- R9: Counts keep their values after done until the next start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Clears all counters for a new frame |
| pix_valid_i | input | 1 | Pixel data is valid |
| pix_ready_o | output | 1 | Block can accept a pixel |
| pix_data_i | input | PIX_W (8) | Pixel intensity |
| pix_last_i | input | 1 | Marks the final pixel of the frame |
| done_o | output | 1 | One-cycle pulse after the last pixel is counted |
| rd_bin_i | input | log2(NUM_BINS) (3) | Bin index to read |
| rd_count_o | output | CNT_W (13) | Count of the selected bin |

## Verification
A sweep of single-pixel frames covers all 256 intensities. Each one checks that exactly the expected bin reads one and that the other seven read zero, which exposes any off-by-one at a range edge. A frame holding every value once must give 32 in each bin. A long frame from a stride pattern gives uneven bins whose expected counts the bench works out arithmetically, which tests accumulation and the read select. A full-size frame in the top bin tests the counter width. Further streams cover valid held low while data and last toggle, and start raised together with a pixel, to show that those transfers are refused and leave the counts unchanged.

// File: rtl/hist_pkg.sv
package hist_pkg;
  // Lower bound of bin k for bins of width bw.
  function automatic int unsigned bin_lo(input int unsigned k, input int unsigned bw);
    return k * bw;
  endfunction

  // Exclusive upper bound of bin k.
  function automatic int unsigned bin_hi(input int unsigned k, input int unsigned bw);
    return (k + 1) * bw;
  endfunction
endpackage

// File: rtl/hist_bin_match.sv
module hist_bin_match #(
  parameter int unsigned PIX_W = 8,
  parameter int unsigned LO    = 0,
  parameter int unsigned HI    = 32
) (
  input  logic [PIX_W-1:0] pix_i,
  output logic             hit_o
);
  localparam logic [PIX_W:0] LO_V = (PIX_W+1)'(LO);
  localparam logic [PIX_W:0] HI_V = (PIX_W+1)'(HI);

  logic [PIX_W:0] pix_ext;
  logic           above_lo;
  logic           below_hi;

  always_comb begin
    pix_ext  = {1'b0, pix_i};
    above_lo = (pix_ext >= LO_V);
    below_hi = (pix_ext <  HI_V);
    hit_o    = above_lo && below_hi;
  end
endmodule

// File: rtl/hist_bin_counter.sv
module hist_bin_counter #(
  parameter int unsigned CNT_W = 13
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr_i,
  input  logic             inc_i,
  output logic [CNT_W-1:0] count_o
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      count_o <= '0;
    end else if (clr_i) begin
      count_o <= '0;
    end else if (inc_i) begin
      count_o <= count_o + CNT_W'(1);
    end
  end
endmodule

// File: rtl/hist_read_mux.sv
module hist_read_mux #(
  parameter int unsigned NUM_BINS = 8,
  parameter int unsigned CNT_W    = 13,
  parameter int unsigned SEL_W    = 3
) (
  input  logic [NUM_BINS-1:0][CNT_W-1:0] counts_i,
  input  logic [SEL_W-1:0]               sel_i,
  output logic [CNT_W-1:0]               data_o
);
  always_comb begin
    data_o = '0;
    for (int i = 0; i < NUM_BINS; i++) begin
      if (sel_i == SEL_W'(i)) data_o = counts_i[i];
    end
  end
endmodule

// File: rtl/intensity_hist.sv
module intensity_hist #(
  parameter int unsigned PIX_W      = 8,
  parameter int unsigned NUM_BINS   = 8,
  parameter int unsigned MAX_PIXELS = 4096,
  localparam int unsigned SEL_W     = $clog2(NUM_BINS),
  localparam int unsigned CNT_W     = $clog2(MAX_PIXELS + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_i,
  input  logic             pix_valid_i,
  output logic             pix_ready_o,
  input  logic [PIX_W-1:0] pix_data_i,
  input  logic             pix_last_i,
  output logic             done_o,
  input  logic [SEL_W-1:0] rd_bin_i,
  output logic [CNT_W-1:0] rd_count_o
);
  import hist_pkg::*;

  localparam int unsigned BIN_W = (2 ** PIX_W) / NUM_BINS;

  logic                           accept;
  logic [NUM_BINS-1:0]            hit;
  logic [NUM_BINS-1:0][CNT_W-1:0] cnt_q;
  logic                           done_q;

  // Start has priority over the pixel stream.
  assign pix_ready_o = !start_i;
  assign accept      = pix_valid_i && pix_ready_o;

  for (genvar k = 0; k < NUM_BINS; k++) begin : g_bin
    hist_bin_match #(
      .PIX_W (PIX_W),
      .LO    (bin_lo(k, BIN_W)),
      .HI    (bin_hi(k, BIN_W))
    ) u_match (
      .pix_i (pix_data_i),
      .hit_o (hit[k])
    );

    hist_bin_counter #(
      .CNT_W (CNT_W)
    ) u_cnt (
      .clk     (clk),
      .rst_n   (rst_n),
      .clr_i   (start_i),
      .inc_i   (accept && hit[k]),
      .count_o (cnt_q[k])
    );
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      done_q <= 1'b0;
    end else begin
      done_q <= accept && pix_last_i;
    end
  end

  assign done_o = done_q;

  hist_read_mux #(
    .NUM_BINS (NUM_BINS),
    .CNT_W    (CNT_W),
    .SEL_W    (SEL_W)
  ) u_rd (
    .counts_i (cnt_q),
    .sel_i    (rd_bin_i),
    .data_o   (rd_count_o)
  );
endmodule

// File: rtl/intensity_hist_chk.sv
module intensity_hist_chk #(
  parameter int unsigned NUM_BINS = 8,
  parameter int unsigned CNT_W    = 13
) (
  input logic                           clk,
  input logic                           rst_n,
  input logic                           start_i,
  input logic                           pix_valid_i,
  input logic                           pix_ready_o,
  input logic                           pix_last_i,
  input logic                           done_o,
  input logic [NUM_BINS-1:0]            hit,
  input logic [NUM_BINS-1:0][CNT_W-1:0] cnt_q
);
  localparam int unsigned TOT_W = CNT_W + $clog2(NUM_BINS) + 1;

  logic [TOT_W-1:0] total;
  logic             taken;

  always_comb begin
    total = '0;
    for (int i = 0; i < NUM_BINS; i++) total = total + TOT_W'(cnt_q[i]);
  end

  assign taken = pix_valid_i && pix_ready_o;

  // R3
  one_bin_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(hit) == 1);

  // R2
  one_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (taken && !start_i) |=> (total == $past(total) + TOT_W'(1)));

  // R4
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!pix_valid_i && !start_i) |=> $stable(cnt_q));

  // R5
  clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start_i |=> (total == '0));

  // R6
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);

  // R6
  done_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done_o) |-> $past(taken && pix_last_i));
endmodule

bind intensity_hist intensity_hist_chk #(
  .NUM_BINS (NUM_BINS),
  .CNT_W    (CNT_W)
) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .start_i     (start_i),
  .pix_valid_i (pix_valid_i),
  .pix_ready_o (pix_ready_o),
  .pix_last_i  (pix_last_i),
  .done_o      (done_o),
  .hit         (hit),
  .cnt_q       (cnt_q)
);

// File: tb/intensity_hist_bench.sv
`timescale 1ns/1ps
module intensity_hist_bench;
  localparam int PW = 8;
  localparam int NB = 8;
  localparam int MAXP = 4096;
  localparam int CW = 13;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          start = 1'b0;
  logic          pv = 1'b0;
  logic          prdy;
  logic [PW-1:0] pd = '0;
  logic          pl = 1'b0;
  logic          done;
  logic [2:0]    rsel = '0;
  logic [CW-1:0] rcnt;

  int checks = 0;
  int errors = 0;
  bit finished = 0;
  int exp_cnt [NB];

  always #10 clk = ~clk;

  intensity_hist #(.PIX_W(PW), .NUM_BINS(NB), .MAX_PIXELS(MAXP)) u_intensity_hist (
    .clk (clk), .rst_n (rst_n), .start_i (start), .pix_valid_i (pv),
    .pix_ready_o (prdy), .pix_data_i (pd), .pix_last_i (pl), .done_o (done),
    .rd_bin_i (rsel), .rd_count_o (rcnt)
  );

  task automatic chk(input int act, input int exp, input string req);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic read_bin(input int b, output int v);
    rsel = 3'(b);
    #1;
    v = int'(rcnt);
  endtask

  task automatic check_bins(input string req);
    int v;
    for (int b = 0; b < NB; b++) begin
      read_bin(b, v);
      chk(v, exp_cnt[b], req);
    end
  endtask

  task automatic clear_exp();
    for (int b = 0; b < NB; b++) exp_cnt[b] = 0;
  endtask

  task automatic do_start();
    @(negedge clk);
    start = 1'b1;
    @(posedge clk);
    #1;
    start = 1'b0;
    clear_exp();
  endtask

  // Drives one pixel for one cycle; returns just after the capturing edge.
  task automatic push(input int v, input bit last);
    @(negedge clk);
    pv = 1'b1;
    pd = PW'(v);
    pl = last;
    @(posedge clk);
    #1;
    pv = 1'b0;
    pl = 1'b0;
    exp_cnt[v / 32]++;
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    int v;
    clear_exp();
    #1;
    // R1: reset state
    chk(int'(done), 0, "R1 done");
    chk(int'(prdy), 1, "R1 ready");
    check_bins("R1 count");
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;

    // R2 R3: single-pixel frame for every intensity
    for (int p = 0; p < 256; p++) begin
      do_start();
      push(p, 1'b1);
      chk(int'(done), 1, "R6 done after last");
      for (int b = 0; b < NB; b++) begin
        read_bin(b, v);
        chk(v, (b == p / 32) ? 1 : 0, (p == 0 || p == 31 || p == 32 || p == 255) ? "R3 edge bin" : "R2 bin");
      end
    end

    // R6: done only one cycle
    @(posedge clk);
    #1;
    chk(int'(done), 0, "R6 done pulse width");

    // R2: every value once
    do_start();
    check_bins("R5 cleared");
    for (int p = 0; p < 256; p++) begin
      push(p, p == 255);
      if (p != 255) chk(int'(done), 0, "R6 done early");
    end
    chk(int'(done), 1, "R6 done");
    for (int b = 0; b < NB; b++) begin
      read_bin(b, v);
      chk(v, 32, "R2 flat frame");
    end

    // R9: counts hold after done
    repeat (5) @(posedge clk);
    #1;
    check_bins("R9 hold");

    // R4: valid low ignores data and last
    for (int i = 0; i < 12; i++) begin
      @(negedge clk);
      pv = 1'b0;
      pd = PW'(i * 53);
      pl = 1'b1;
      @(posedge clk);
      #1;
      chk(int'(done), 0, "R4 no done");
    end
    pl = 1'b0;
    check_bins("R4 counts unchanged");

    // R5: pixel offered with start is refused
    @(negedge clk);
    start = 1'b1;
    pv = 1'b1;
    pd = 8'd200;
    pl = 1'b1;
    #1;
    chk(int'(prdy), 0, "R5 ready low");
    @(posedge clk);
    #1;
    start = 1'b0;
    pv = 1'b0;
    pl = 1'b0;
    clear_exp();
    check_bins("R5 cleared with pixel");
    @(posedge clk);
    #1;
    chk(int'(done), 0, "R5 no done");
    chk(int'(prdy), 1, "R5 ready back");

    // R7 R8: stride pattern, uneven bins
    do_start();
    for (int i = 0; i < 3000; i++) push((i * 37 + i / 5) % 256, i == 2999);
    chk(int'(done), 1, "R6 done stride");
    check_bins("R7 R8 stride counts");
    v = 0;
    for (int b = 0; b < NB; b++) v += exp_cnt[b];
    chk(v, 3000, "R7 total");

    // R7: full-size frame in the top bin
    do_start();
    for (int i = 0; i < MAXP; i++) push(224 + (i % 32), i == MAXP - 1);
    check_bins("R7 no wrap");

    finish_run();
  end
endmodule